// File: doc/BRIEF.md
# Buffered-Modulo PWM Timer Channel

A 16-bit up-counting timer with one edge-aligned PWM output and one overflow flag with interrupt. A CPU writes the period limit (the modulo) one byte at a time over an 8-bit register port. Each byte lands in a write buffer. The active modulo is replaced only when both bytes of a new value are present. The moment of replacement depends on whether the timer is counting. While the clock-select field is 00 the new value takes effect as soon as the second byte arrives. While the timer runs, the new value waits for a defined point in the count sequence, so that a half-written value never reaches the counter.

Two commit points are available when running, chosen at build time. The default policy commits as the counter steps into the new value, or from 0xFFFE to 0xFFFF when the active modulo is zero (free running). The alternative policy commits at the wrap to zero. Under that policy, software that rewrites the period in every overflow handler sees the old period run once more before the new one applies.

Top module: `pwm_modtimer`

Register map (addr): 0 control/status, 1 count high, 2 count low, 3 modulo high, 4 modulo low, 5 compare high, 6 compare low. Control bits: [7] overflow flag, [6] interrupt enable, [5] PWM enable, [1:0] clock select (00 stops the timer; any other value counts once per clock).

## Requirements
- R1: After reset the count, the active modulo, the compare value and the control register read 0, and pwm_o, ovf_o and irq_o are low.
- R2: A write to only one modulo byte (addr 3 or 4) leaves the active modulo, as read back at addr 3/4, unchanged.
- R3: While clock select is 00, the active modulo takes the buffered 16-bit value at the write of the second byte, in either byte order. Reads of addr 3/4 return the active modulo.
- R4: Any write to the control register (addr 0) forgets the modulo bytes written before it, so a byte written before the control write does not pair with one written after it.
- R5: With the default policy and the timer running, a complete buffered value V is committed as the counter steps from V-1 to V. A smaller modulo written early in a period therefore ends that same period after V+1 cycles.
- R6: With the default policy, when the active modulo is 0 the counter runs to 0xFFFF, and a pending value is committed only as the counter steps from 0xFFFE to 0xFFFF.
- R7: With COMMIT_AT_WRAP set, a pending value is committed at the wrap to 0. A value written in each overflow handler gives periods old+1, then new+1, one period late.
- R8: While running, the counter goes 0 up to the active modulo and wraps to 0, giving a period of modulo+1 clocks. Each wrap sets the overflow flag (bit 7). irq_o is high exactly when the flag and the enable (bit 6) are both set.
- R9: The overflow flag is cleared only by a write of 0 to bit 7 that follows a read of addr 0 made while the flag was set. Without that read the flag stays set.
- R10: With PWM enable (bit 5) set, pwm_o is high while the count is below the compare value (addr 5/6) and low otherwise, so it is high for exactly that many clocks per period.
- R11: A write to either count byte (addr 1 or 2) forces the count to 0, which reads back at addr 1/2.
- R12: While clock select is 00 the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register address |
| wr | input | 1 | Write strobe, one cycle per byte |
| rd | input | 1 | Read strobe; data appears on rdata the next cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pwm_o | output | 1 | Edge-aligned PWM output |
| ovf_o | output | 1 | Overflow flag |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The hardest situation to reach from the ports is a commit on a running timer. It happens on one specific counter step, which software cannot see directly. The bench behaves like an interrupt handler: on each rise of irq_o it reads status, clears the flag and writes a new modulo within the first few counts of the period. It then measures the spacing of interrupt edges and the PWM high time to show in which period the value took hold, for both commit policies. The free-running case waits more than 65,536 cycles. It reads the modulo long after the counter has passed the new value, where the value must still be pending, and again after the 0xFFFE step.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_CNT_HI = 3'd1,
    A_CNT_LO = 3'd2,
    A_MOD_HI = 3'd3,
    A_MOD_LO = 3'd4,
    A_CMP_HI = 3'd5,
    A_CMP_LO = 3'd6
  } reg_addr_e;

  localparam int CB_FLAG = 7;
  localparam int CB_IE   = 6;
  localparam int CB_PWM  = 5;
  localparam int CLKS_W  = 2;
endpackage

// File: rtl/pmt_modbuf.sv
module pmt_modbuf import pmt_pkg::*; #(
  parameter bit COMMIT_AT_WRAP = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             wr_hi,
  input  logic             wr_lo,
  input  logic             wr_ctrl,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] mod_q,
  output logic [CNT_W-1:0] term
);
  logic [BYTE_W-1:0] buf_hi, buf_lo;
  logic              hi_seen, lo_seen;
  logic [CNT_W-1:0]  buf_val, target, stop_val;
  logic              pending, stop_commit, at_step, at_wrap, run_commit;

  assign buf_val  = {buf_hi, buf_lo};
  assign term     = (mod_q == '0) ? '1 : mod_q;
  assign target   = (mod_q == '0) ? '1 : buf_val;
  assign pending  = hi_seen && lo_seen;
  assign stop_val = {wr_hi ? wdata : buf_hi, wr_lo ? wdata : buf_lo};

  // Clock stopped: second byte completes the pair and commits at once
  assign stop_commit = !run && ((wr_lo && hi_seen) || (wr_hi && lo_seen));
  // Running: counter steps from target-1 into target
  assign at_step    = (cnt_q == target - 1'b1) && (cnt_q != term);
  // Running, alternative policy: counter wraps to zero
  assign at_wrap    = (cnt_q == term);
  assign run_commit = run && pending && (COMMIT_AT_WRAP ? at_wrap : at_step);

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_hi  <= '0;
      buf_lo  <= '0;
      hi_seen <= 1'b0;
      lo_seen <= 1'b0;
      mod_q   <= '0;
    end else begin
      if (wr_hi) buf_hi <= wdata;
      if (wr_lo) buf_lo <= wdata;
      if (wr_ctrl || stop_commit || run_commit) begin
        hi_seen <= 1'b0;
        lo_seen <= 1'b0;
      end else begin
        if (wr_hi) hi_seen <= 1'b1;
        if (wr_lo) lo_seen <= 1'b1;
      end
      if (stop_commit)     mod_q <= stop_val;
      else if (run_commit) mod_q <= buf_val;
    end
  end

  // R2
  single_byte_chk: assert property (@(posedge clk) disable iff (rst)
    ((wr_hi && !wr_lo && !lo_seen) || (wr_lo && !wr_hi && !hi_seen)) |=> $stable(mod_q));

  // R5
  run_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !pending) |=> $stable(mod_q));
endmodule

// File: rtl/pmt_counter.sv
module pmt_counter import pmt_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clr,
  input  logic [CNT_W-1:0] term,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d,
  output logic             wrap
);
  assign wrap = run && !clr && (cnt_q == term);

  always_comb begin
    if (clr)       cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else if (run)  cnt_d = cnt_q + 1'b1;
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  // R8
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !clr && cnt_q == term) |=> (cnt_q == '0));

  // R11
  count_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0));

  // R12
  stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/pmt_pwm.sv
module pmt_pwm import pmt_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt_d,
  output logic [CNT_W-1:0]  cmp_q,
  output logic              pwm_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '0;
      pwm_q <= 1'b0;
    end else begin
      if (wr_hi) cmp_q[CNT_W-1:BYTE_W] <= wdata;
      if (wr_lo) cmp_q[BYTE_W-1:0]     <= wdata;
      pwm_q <= en && (cnt_d < cmp_q);
    end
  end

  // R10
  pwm_enable_chk: assert property (@(posedge clk) disable iff (rst)
    pwm_q |-> $past(en));
endmodule

// File: rtl/pwm_modtimer.sv
module pwm_modtimer import pmt_pkg::*; #(
  parameter bit COMMIT_AT_WRAP = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              pwm_o,
  output logic              ovf_o,
  output logic              irq_o
);
  logic [CLKS_W-1:0] clks_q;
  logic              ie_q, pwm_en_q, flag_q, arm_q, irq_q;
  logic              flag_d, ie_d, run, wr_ctrl, flag_clr, wrap;
  logic [BYTE_W-1:0] rdata_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d, mod_q, term, cmp_q;

  assign run      = (clks_q != '0);
  assign wr_ctrl  = wr && (addr == A_CTRL);
  assign flag_clr = wr_ctrl && arm_q && !wdata[CB_FLAG];
  assign flag_d   = wrap ? 1'b1 : (flag_clr ? 1'b0 : flag_q);
  assign ie_d     = wr_ctrl ? wdata[CB_IE] : ie_q;

  pmt_modbuf #(.COMMIT_AT_WRAP(COMMIT_AT_WRAP)) u_modbuf (
    .clk(clk), .rst(rst), .run(run),
    .wr_hi(wr && (addr == A_MOD_HI)), .wr_lo(wr && (addr == A_MOD_LO)),
    .wr_ctrl(wr_ctrl), .wdata(wdata), .cnt_q(cnt_q),
    .mod_q(mod_q), .term(term)
  );

  pmt_counter u_counter (
    .clk(clk), .rst(rst), .run(run),
    .clr(wr && (addr == A_CNT_HI || addr == A_CNT_LO)),
    .term(term), .cnt_q(cnt_q), .cnt_d(cnt_d), .wrap(wrap)
  );

  pmt_pwm u_pwm (
    .clk(clk), .rst(rst), .en(pwm_en_q),
    .wr_hi(wr && (addr == A_CMP_HI)), .wr_lo(wr && (addr == A_CMP_LO)),
    .wdata(wdata), .cnt_d(cnt_d), .cmp_q(cmp_q), .pwm_q(pwm_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      clks_q   <= '0;
      ie_q     <= 1'b0;
      pwm_en_q <= 1'b0;
      flag_q   <= 1'b0;
      arm_q    <= 1'b0;
      irq_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        clks_q   <= wdata[CLKS_W-1:0];
        ie_q     <= wdata[CB_IE];
        pwm_en_q <= wdata[CB_PWM];
        arm_q    <= 1'b0;
      end else if (rd && addr == A_CTRL && flag_q) begin
        arm_q <= 1'b1;
      end
      flag_q <= flag_d;
      irq_q  <= flag_d && ie_d;
      if (rd) begin
        case (addr)
          A_CTRL:   rdata_q <= {flag_q, ie_q, pwm_en_q, {(BYTE_W-3-CLKS_W){1'b0}}, clks_q};
          A_CNT_HI: rdata_q <= cnt_q[CNT_W-1:BYTE_W];
          A_CNT_LO: rdata_q <= cnt_q[BYTE_W-1:0];
          A_MOD_HI: rdata_q <= mod_q[CNT_W-1:BYTE_W];
          A_MOD_LO: rdata_q <= mod_q[BYTE_W-1:0];
          A_CMP_HI: rdata_q <= cmp_q[CNT_W-1:BYTE_W];
          A_CMP_LO: rdata_q <= cmp_q[BYTE_W-1:0];
          default:  rdata_q <= '0;
        endcase
      end
    end
  end

  assign rdata = rdata_q;
  assign ovf_o = flag_q;
  assign irq_o = irq_q;

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !(wr_ctrl && arm_q && !wdata[CB_FLAG])) |=> flag_q);

  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (flag_q && ie_q));
endmodule

// File: tb/tb_pwm_modtimer.sv
module tb_pwm_modtimer;
  import pmt_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic wr = 1'b0, rd = 1'b0, sel = 1'b0, mon_on = 1'b0;
  logic [7:0] rdata0, rdata1, rdata_s;
  logic pwm0, pwm1, ovf0, ovf1, irq0, irq1, irq_s, pwm_s;
  int errors = 0, checks = 0;

  typedef struct { int per; int hi; string tag; } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  pwm_modtimer dut (
    .clk(clk), .rst(rst), .addr(addr), .wr(wr && !sel), .rd(rd && !sel),
    .wdata(wdata), .rdata(rdata0), .pwm_o(pwm0), .ovf_o(ovf0), .irq_o(irq0));

  pwm_modtimer #(.COMMIT_AT_WRAP(1'b1)) dut_wrap (
    .clk(clk), .rst(rst), .addr(addr), .wr(wr && sel), .rd(rd && sel),
    .wdata(wdata), .rdata(rdata1), .pwm_o(pwm1), .ovf_o(ovf1), .irq_o(irq1));

  assign rdata_s = sel ? rdata1 : rdata0;
  assign irq_s   = sel ? irq1 : irq0;
  assign pwm_s   = sel ? pwm1 : pwm0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata_s;
  endtask

  task automatic wait_irq();
    do @(negedge clk); while (!irq_s);
  endtask

  // Handler: acknowledge the overflow, rewrite the modulo, push the expected interval
  task automatic isr(input logic [15:0] newmod, input int exp_per, input string tag);
    logic [7:0] d;
    wait_irq();
    q.push_back('{per: exp_per, hi: 10, tag: tag});
    rreg(A_CTRL, d);
    wreg(A_CTRL, 8'h61);
    wreg(A_MOD_HI, newmod[15:8]);
    wreg(A_MOD_LO, newmod[7:0]);
  endtask

  // Monitor: measure period and PWM high time between interrupt rises
  initial begin
    int per, hi;
    logic prev, started;
    per = 0; hi = 0; prev = 1'b0; started = 1'b0;
    forever begin
      @(negedge clk);
      if (!mon_on) begin
        started = 1'b0;
        prev = irq_s;
      end else begin
        if (irq_s && !prev) begin
          if (started && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check({e.tag, " R8 period"}, per, e.per);
            check("R10 pwm high time", hi, e.hi);
          end
          started = 1'b1;
          per = 0;
          hi = 0;
        end
        per++;
        if (pwm_s) hi++;
        prev = irq_s;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d, a0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 pwm", int'(pwm0), 0);
    check("R1 irq", int'(irq0), 0);
    check("R1 ovf", int'(ovf0), 0);
    rreg(A_CTRL, d);   check("R1 ctrl", d, 0);
    rreg(A_MOD_LO, d); check("R1 modulo", d, 0);
    rreg(A_CNT_LO, d); check("R1 count", d, 0);
    rreg(A_CMP_LO, d); check("R1 compare", d, 0);

    // R2 / R3 / R4 with the timer stopped
    wreg(A_MOD_HI, 8'h12);
    rreg(A_MOD_HI, d); check("R2 high byte alone", d, 8'h00);
    wreg(A_MOD_LO, 8'h34);
    rreg(A_MOD_HI, d); check("R3 high after pair", d, 8'h12);
    rreg(A_MOD_LO, d); check("R3 low after pair", d, 8'h34);
    wreg(A_MOD_HI, 8'h00);
    wreg(A_CTRL, 8'h00);
    wreg(A_MOD_LO, 8'h28);
    rreg(A_MOD_LO, d); check("R4 pair broken by ctrl write", d, 8'h34);
    rreg(A_MOD_HI, d); check("R4 high unchanged", d, 8'h12);
    wreg(A_MOD_HI, 8'h00);
    rreg(A_MOD_LO, d); check("R3 low-then-high order", d, 8'h28);
    rreg(A_MOD_HI, d); check("R3 high in reverse order", d, 8'h00);

    // R5 / R8 / R10: running, default policy, shrinking period (modulo 40)
    wreg(A_CMP_HI, 8'h00);
    wreg(A_CMP_LO, 8'd10);
    mon_on = 1'b1;
    wreg(A_CTRL, 8'h61);
    isr(16'd34, 35, "R5");
    isr(16'd28, 29, "R5");
    isr(16'd22, 23, "R5");
    wait_irq();

    // R9 flag clear protocol
    wreg(A_CTRL, 8'h61);
    check("R9 flag kept without status read", int'(irq0), 1);
    check("R9 ovf kept", int'(ovf0), 1);
    mon_on = 1'b0;
    rreg(A_CTRL, d);
    check("R9 status shows flag", int'(d[7]), 1);
    wreg(A_CTRL, 8'h61);
    check("R9 irq cleared", int'(irq0), 0);
    check("R9 ovf cleared", int'(ovf0), 0);
    wreg(A_CTRL, 8'h00);
    check("R5 all intervals seen", q.size(), 0);

    // R12 hold while stopped, R11 counter write
    rreg(A_CNT_LO, a0);
    repeat (6) @(negedge clk);
    rreg(A_CNT_LO, d); check("R12 count holds", d, a0);
    wreg(A_CNT_HI, 8'h55);
    rreg(A_CNT_LO, d); check("R11 count low cleared", d, 0);
    rreg(A_CNT_HI, d); check("R11 count high cleared", d, 0);

    // R6 free-running commit point
    wreg(A_MOD_HI, 8'h00);
    wreg(A_MOD_LO, 8'h00);
    wreg(A_CTRL, 8'h01);
    wreg(A_MOD_HI, 8'h00);
    wreg(A_MOD_LO, 8'd100);
    repeat (1000) @(negedge clk);
    rreg(A_MOD_LO, d); check("R6 still pending past count 100", d, 0);
    repeat (65000) @(negedge clk);
    rreg(A_MOD_LO, d); check("R6 committed after 0xFFFE step", d, 100);
    wreg(A_CTRL, 8'h00);

    // R7 wrap policy on the second instance
    sel = 1'b1;
    wreg(A_CMP_LO, 8'd10);
    wreg(A_MOD_HI, 8'h00);
    wreg(A_MOD_LO, 8'd20);
    rreg(A_MOD_LO, d); check("R3 immediate on wrap instance", d, 20);
    mon_on = 1'b1;
    wreg(A_CTRL, 8'h61);
    isr(16'd30, 21, "R7");
    isr(16'd40, 31, "R7");
    isr(16'd50, 41, "R7");
    wait_irq();
    repeat (2) @(negedge clk);
    mon_on = 1'b0;
    check("R7 all intervals seen", q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule